// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block generates the word address for the streaming side of a 4096-word memory. The memory is split into two buffers, and each buffer has a start address, an end address and a flow mode. These settings come in as plain inputs from a separate command register block. The pointer moves in one of three ways:

- It loads an arbitrary address through a two-stage path.
- It jumps in one cycle to the start of buffer 1 or buffer 2.
- It counts upward when enabled.

Each buffer has a sticky active-low end-of-buffer flag. When the pointer reaches the end of the buffer it is walking, that buffer's flag is set. The pointer then either hops to the other buffer's start (chaining) or parks at the end (stop). A start strobe that arrives while a load is still in progress is a protocol error. The block ignores it and reports it on a registered error output.

Top module: `seq_addr_pointer`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state on that edge: `ptr` = 0, `eob1_n` = 1, `eob2_n` = 1, `proto_err` = 0, and buffer 1 becomes the active buffer.
- R2: When `load_n` is sampled low, the edge stores `load_val`. `ptr` takes the stored value on the next rising edge, not on the edge that sampled the load. A load does not change which buffer is active.
- R3: On the edge that samples `load_n` low, and on the edge after it, `cnt_en_n` has no effect on `ptr`.
- R4: With no load in progress, a low `start1_n` loads `buf1_start` into `ptr` on that edge and makes buffer 1 active. A low `start2_n` does the same with `buf2_start` and buffer 2.
- R5: If both start strobes are low together, `start1_n` wins.
- R6: With no load or start pending, a low `cnt_en_n` adds 1 to `ptr`, modulo 4096. The count from 4095 goes to 0.
- R7: In chaining mode (the active buffer's stop bit = 0), counting while `ptr` equals the active buffer's end address does three things on that edge: it drives that buffer's flag low, moves `ptr` to the other buffer's start address, and makes the other buffer active.
- R8: In stop mode (stop bit = 1), counting while `ptr` equals the active buffer's end address leaves `ptr` unchanged and drives that buffer's flag low.
- R9: A flag stays low until its clear bit is high at an edge. `eob_clr[0]` clears `eob1_n` and `eob_clr[1]` clears `eob2_n`. If a set and a clear hit the same flag on the same edge, the flag is set (low).
- R10: A low start strobe on the edge that samples `load_n` low, or on the edge after it, raises `proto_err` for exactly the next cycle. That start strobe is otherwise ignored, and the load completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low address load strobe |
| start1_n | input | 1 | Active-low jump to buffer 1 start |
| start2_n | input | 1 | Active-low jump to buffer 2 start |
| cnt_en_n | input | 1 | Active-low count enable |
| load_val | input | 12 | Address to load |
| buf1_start | input | 12 | Buffer 1 first address |
| buf1_end | input | 12 | Buffer 1 last address |
| buf2_start | input | 12 | Buffer 2 first address |
| buf2_end | input | 12 | Buffer 2 last address |
| buf1_stop | input | 1 | Buffer 1 flow mode: 1 = stop, 0 = chain |
| buf2_stop | input | 1 | Buffer 2 flow mode: 1 = stop, 0 = chain |
| eob_clr | input | 2 | Flag clear pulses: bit 0 = buffer 1, bit 1 = buffer 2 |
| ptr | output | 12 | Current address pointer |
| eob1_n | output | 1 | Buffer 1 end-of-buffer flag, active low |
| eob2_n | output | 1 | Buffer 2 end-of-buffer flag, active low |
| proto_err | output | 1 | Start strobe seen during a load |

## Verification
The bench builds the block with the default 12-bit address width. Both buffers are given very short windows (addresses 16 to 19 and 100 to 102), so chaining in both directions, stop-mode parking and the set-beats-clear case each occur within a few counts. A load of 4095 followed by a count brings the modulo-4096 wrap within reach without walking the whole space. A mid-run reset confirms that pointer, flags and active buffer all return to their initial values.

// File: rtl/seq_ptr_pkg.sv
package seq_ptr_pkg;
  typedef enum logic {
    BUF_ONE = 1'b0,
    BUF_TWO = 1'b1
  } buf_id_t;
endpackage

// File: rtl/seq_load_stage.sv
// Two-stage load path: captures the address, then flags it pending for one cycle.
module seq_load_stage #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic [AW-1:0] load_val,
  output logic          load_pend,
  output logic [AW-1:0] load_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load_pend <= 1'b0;
      load_data <= '0;
    end else begin
      load_pend <= ~load_n;
      if (!load_n) load_data <= load_val;
    end
  end

  // R2: a sampled load is pending on the very next cycle
  assert_load_pends_R2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> load_pend);
endmodule

// File: rtl/seq_buf_select.sv
// Picks the limits of the active buffer and the start of the other one.
module seq_buf_select
  import seq_ptr_pkg::*;
#(
  parameter int AW = 12
) (
  input  buf_id_t       active,
  input  logic [AW-1:0] buf1_start,
  input  logic [AW-1:0] buf1_end,
  input  logic [AW-1:0] buf2_start,
  input  logic [AW-1:0] buf2_end,
  input  logic          buf1_stop,
  input  logic          buf2_stop,
  output logic [AW-1:0] cur_end,
  output logic [AW-1:0] alt_start,
  output logic          cur_stop
);
  always_comb begin
    if (active == BUF_ONE) begin
      cur_end   = buf1_end;
      alt_start = buf2_start;
      cur_stop  = buf1_stop;
    end else begin
      cur_end   = buf2_end;
      alt_start = buf1_start;
      cur_stop  = buf2_stop;
    end
  end
endmodule

// File: rtl/seq_eob_flags.sv
// Sticky active-low end-of-buffer flags; a set beats a clear.
module seq_eob_flags #(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] set_i,
  input  logic [NBUF-1:0] clr_i,
  output logic [NBUF-1:0] eob_n_o
);
  for (genvar k = 0; k < NBUF; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           eob_n_o[k] <= 1'b1;
      else if (set_i[k]) eob_n_o[k] <= 1'b0;
      else if (clr_i[k]) eob_n_o[k] <= 1'b1;
    end

    // R9: a set always lands, even with a clear on the same edge
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> !eob_n_o[k]);
    // R9: a flag that is neither set nor cleared keeps its value
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (!set_i[k] && !clr_i[k]) |=> $stable(eob_n_o[k]));
  end
endmodule

// File: rtl/seq_addr_pointer.sv
module seq_addr_pointer
  import seq_ptr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          start1_n,
  input  logic          start2_n,
  input  logic          cnt_en_n,
  input  logic [AW-1:0] load_val,
  input  logic [AW-1:0] buf1_start,
  input  logic [AW-1:0] buf1_end,
  input  logic [AW-1:0] buf2_start,
  input  logic [AW-1:0] buf2_end,
  input  logic          buf1_stop,
  input  logic          buf2_stop,
  input  logic [1:0]    eob_clr,
  output logic [AW-1:0] ptr,
  output logic          eob1_n,
  output logic          eob2_n,
  output logic          proto_err
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          load_pend;
  logic [AW-1:0] load_data;
  logic [AW-1:0] cur_end, alt_start;
  logic          cur_stop;
  buf_id_t       active_q;
  logic [1:0]    eob_set, eob_n;

  seq_load_stage #(.AW(AW)) u_load (
    .clk(clk), .rst(rst), .load_n(load_n), .load_val(load_val),
    .load_pend(load_pend), .load_data(load_data)
  );

  seq_buf_select #(.AW(AW)) u_sel (
    .active(active_q),
    .buf1_start(buf1_start), .buf1_end(buf1_end),
    .buf2_start(buf2_start), .buf2_end(buf2_end),
    .buf1_stop(buf1_stop), .buf2_stop(buf2_stop),
    .cur_end(cur_end), .alt_start(alt_start), .cur_stop(cur_stop)
  );

  logic busy, start_req, viol, cnt_go, at_end;
  assign busy      = ~load_n | load_pend;
  assign start_req = ~start1_n | ~start2_n;
  assign viol      = busy & start_req;
  assign cnt_go    = ~busy & ~start_req & ~cnt_en_n;
  assign at_end    = (ptr == cur_end);

  always_comb begin
    eob_set = 2'b00;
    if (cnt_go && at_end) eob_set[active_q] = 1'b1;
  end

  seq_eob_flags #(.NBUF(2)) u_flags (
    .clk(clk), .rst(rst), .set_i(eob_set), .clr_i(eob_clr), .eob_n_o(eob_n)
  );
  assign eob1_n = eob_n[0];
  assign eob2_n = eob_n[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      active_q  <= BUF_ONE;
      proto_err <= 1'b0;
    end else begin
      proto_err <= viol;
      if (load_pend) begin
        ptr <= load_data;
      end else if (!load_n) begin
        ptr <= ptr;
      end else if (!start1_n) begin
        ptr      <= buf1_start;
        active_q <= BUF_ONE;
      end else if (!start2_n) begin
        ptr      <= buf2_start;
        active_q <= BUF_TWO;
      end else if (!cnt_en_n) begin
        if (at_end) begin
          if (!cur_stop) begin
            ptr      <= alt_start;
            active_q <= (active_q == BUF_ONE) ? BUF_TWO : BUF_ONE;
          end
        end else begin
          ptr <= ptr + ONE;
        end
      end
    end
  end

  // R2: the pending stage delivers the captured address
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (rst)
    load_pend |=> ptr == $past(load_data));
  // R3: the capture edge holds the pointer whatever cnt_en_n says
  assert_count_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !load_pend) |=> $stable(ptr));
  // R5: start-1 wins when both strobes fall together
  assert_start1_first_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start1_n && !start2_n) |=> ptr == $past(buf1_start));
  // R8: stop mode parks the pointer at the end address
  assert_stop_parks_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_go && at_end && cur_stop) |=> $stable(ptr));
  // R10: a start during a load is reported next cycle
  assert_proto_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (start_req && (!load_n || load_pend)) |=> proto_err);
endmodule

// File: tb/seq_addr_pointer_bench.sv
`timescale 1ns/1ps
module seq_addr_pointer_bench;
  localparam int AW = 12;

  typedef struct packed {
    logic          ld;
    logic          s1;
    logic          s2;
    logic          cn;
    logic [1:0]    clr;
    logic [AW-1:0] lv;
    logic          m2;
    logic [AW-1:0] xp;
    logic          x1;
    logic          x2;
    logic          xe;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 26;
  // fields: ld s1 s2 cn clr lv m2 | exp ptr eob1 eob2 err | requirement
  localparam vec_t VEC [NV] = '{
    '{1,0,1,1,2'b00,12'd0,   0, 12'd16,  1,1,0, 4'd4},  // R4 jump to buf1
    '{1,1,1,0,2'b00,12'd0,   0, 12'd17,  1,1,0, 4'd6},  // R6
    '{1,1,1,0,2'b00,12'd0,   0, 12'd18,  1,1,0, 4'd6},
    '{1,1,1,0,2'b00,12'd0,   0, 12'd19,  1,1,0, 4'd6},
    '{1,1,1,0,2'b00,12'd0,   0, 12'd100, 0,1,0, 4'd7},  // R7 chain 1->2
    '{1,1,1,0,2'b00,12'd0,   0, 12'd101, 0,1,0, 4'd6},
    '{1,1,1,1,2'b00,12'd0,   0, 12'd101, 0,1,0, 4'd6},  // idle holds
    '{1,1,1,0,2'b00,12'd0,   0, 12'd102, 0,1,0, 4'd6},
    '{1,1,1,0,2'b00,12'd0,   0, 12'd16,  0,0,0, 4'd7},  // R7 chain 2->1
    '{1,1,1,1,2'b01,12'd0,   0, 12'd16,  1,0,0, 4'd9},  // R9 clear buf1 flag
    '{0,1,1,0,2'b00,12'd500, 0, 12'd16,  1,0,0, 4'd3},  // R3 capture edge
    '{1,1,1,0,2'b00,12'd0,   0, 12'd500, 1,0,0, 4'd2},  // R2 lands, R3 no count
    '{1,1,1,0,2'b00,12'd0,   0, 12'd501, 1,0,0, 4'd6},
    '{1,1,0,1,2'b10,12'd0,   0, 12'd100, 1,1,0, 4'd4},  // R4 jump to buf2
    '{1,1,1,0,2'b00,12'd0,   1, 12'd101, 1,1,0, 4'd6},
    '{1,1,1,0,2'b00,12'd0,   1, 12'd102, 1,1,0, 4'd6},
    '{1,1,1,0,2'b00,12'd0,   1, 12'd102, 1,0,0, 4'd8},  // R8 stop parks
    '{1,1,1,0,2'b00,12'd0,   1, 12'd102, 1,0,0, 4'd8},
    '{1,1,1,0,2'b10,12'd0,   1, 12'd102, 1,0,0, 4'd9},  // R9 set beats clear
    '{1,0,0,1,2'b00,12'd0,   0, 12'd16,  1,0,0, 4'd5},  // R5 both starts
    '{0,1,0,1,2'b00,12'd7,   0, 12'd16,  1,0,1, 4'd10}, // R10 start with load
    '{1,0,1,1,2'b00,12'd0,   0, 12'd7,   1,0,1, 4'd10}, // R10 start in pend
    '{1,1,1,1,2'b00,12'd0,   0, 12'd7,   1,0,0, 4'd10}, // error drops
    '{0,1,1,1,2'b00,12'd4095,0, 12'd7,   1,0,0, 4'd2},
    '{1,1,1,0,2'b00,12'd0,   0, 12'd4095,1,0,0, 4'd2},
    '{1,1,1,0,2'b00,12'd0,   0, 12'd0,   1,0,0, 4'd6}   // R6 wrap
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_n = 1'b1, start1_n = 1'b1, start2_n = 1'b1, cnt_en_n = 1'b1;
  logic [AW-1:0] load_val = '0;
  logic [AW-1:0] buf1_start = 12'd16, buf1_end = 12'd19;
  logic [AW-1:0] buf2_start = 12'd100, buf2_end = 12'd102;
  logic buf1_stop = 1'b0, buf2_stop = 1'b0;
  logic [1:0] eob_clr = 2'b00;
  logic [AW-1:0] ptr;
  logic eob1_n, eob2_n, proto_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  seq_addr_pointer #(.AW(AW)) u_seq_addr_pointer (
    .clk(clk), .rst(rst), .load_n(load_n), .start1_n(start1_n),
    .start2_n(start2_n), .cnt_en_n(cnt_en_n), .load_val(load_val),
    .buf1_start(buf1_start), .buf1_end(buf1_end),
    .buf2_start(buf2_start), .buf2_end(buf2_end),
    .buf1_stop(buf1_stop), .buf2_stop(buf2_stop), .eob_clr(eob_clr),
    .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n), .proto_err(proto_err)
  );

  task automatic check_out(input string tag, input logic [AW-1:0] xp,
                           input logic x1, input logic x2, input logic xe);
    checks++;
    if (ptr !== xp || eob1_n !== x1 || eob2_n !== x2 || proto_err !== xe) begin
      fails++;
      $display("FAIL %s: got ptr=%0d eob1_n=%b eob2_n=%b err=%b, expected ptr=%0d eob1_n=%b eob2_n=%b err=%b",
               tag, ptr, eob1_n, eob2_n, proto_err, xp, x1, x2, xe);
    end
  endtask

  task automatic idle_inputs();
    load_n = 1'b1; start1_n = 1'b1; start2_n = 1'b1; cnt_en_n = 1'b1;
    eob_clr = 2'b00; buf2_stop = 1'b0; load_val = '0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_out("R1 reset state", 12'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      load_n = VEC[i].ld; start1_n = VEC[i].s1; start2_n = VEC[i].s2;
      cnt_en_n = VEC[i].cn; eob_clr = VEC[i].clr; load_val = VEC[i].lv;
      buf2_stop = VEC[i].m2;
      @(posedge clk);
      #1;
      check_out($sformatf("R%0d table step %0d", VEC[i].rq, i),
                VEC[i].xp, VEC[i].x1, VEC[i].x2, VEC[i].xe);
      @(negedge clk);
    end

    // R1: mid-run reset returns everything, active buffer back to buf1
    idle_inputs();
    start2_n = 1'b0;
    @(negedge clk);
    start2_n = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_out("R1 mid-run reset", 12'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    load_n = 1'b0; load_val = 12'd19;
    @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    cnt_en_n = 1'b0;
    @(posedge clk);
    #1;
    // R1/R2: active buffer after reset is buf1, load left it so: end 19 chains to 100
    check_out("R1 active buffer after reset", 12'd100, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    idle_inputs();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule